// File: doc/BRIEF.md
# Transaction Domain Tagger

This block sits on the request path of a single bus master. For every transaction it produces a domain identifier, a nonsecure flag and a privileged flag, which downstream access checkers use to decide whether the access is allowed. The attributes do not depend only on which master issued the transaction. They are chosen per transaction by comparing the sideband ID bits of the master against a programmable table of descriptors.

Each descriptor holds an enable, a compare value, a don't-care mask, a domain number, two attribute bits and a lock bit. A runtime format select decides how the sideband ID is assembled into the 28-bit compare key. One format takes a 6-bit extended ID from a single-channel bus. The other takes the ID and user-high fields of the write and read channels of a split-channel bus. The same master can land in different domains from one transaction to the next, depending on the ID bits it presents.

Software programs the table through a simple write port. Writing to a locked descriptor has no effect until the next reset.

Top module: `domain_tagger`

## Requirements
- R1: The tag outputs are registered. `tag_valid` is high exactly in the cycle after a cycle in which `req_valid` was high, and the attributes of that request are presented in that same cycle.
- R2: The table holds NUM_DESC (16) descriptors, indexed 0 to 15. Each descriptor has its own enable, which is control bit 0. A disabled descriptor never takes part in matching, and index 15 works like any other index.
- R3: A descriptor hits when `((key XOR compare) AND NOT mask) == 0`. A mask bit of 1 makes that key bit don't-care, and a mask of 0 requires an exact match.
- R4: When several enabled descriptors hit, the one with the lowest index supplies the attributes.
- R5: When no enabled descriptor hits, the tag is domain 0, nonsecure 1 and privileged 0, and `tag_miss` is 1.
- R6: `nomatch_sticky` goes to 1 after any request that found no hit. After that it stays 1 until reset.
- R7: With `fmt_axi`=1 the key is {`axi_awuser_hi`[7:0], `axi_awid`[5:0], `axi_aruser_hi`[7:0], `axi_arid`[5:0]}. The first field listed occupies key bits 27:20.
- R8: With `fmt_axi`=0 the key is `ahb_xid` in bits 5:0, and key bits 27:6 are zero.
- R9: A table write applies only to requests that start after the write cycle. A request presented in the same cycle as a write is tagged from the old table contents.
- R10: The write port uses `cfg_sel` to choose the word: 0 writes the control word, 1 writes the compare value and 2 writes the mask, using data bits 27:0. In the control word, bit 1 is nonsecure, bit 2 is privileged, bits 7:4 are the domain and bit 31 is the lock. The write that sets the lock is itself applied. After that, every write to that descriptor is ignored until reset.
- R11: Reset clears every descriptor: all are disabled and unlocked, with zero fields. It also clears `tag_valid`, `tag_miss` and `nomatch_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W (4) | Descriptor index for the write |
| cfg_sel | input | 2 | Word select: control, compare value or mask |
| cfg_data | input | 32 | Write data |
| req_valid | input | 1 | Transaction request strobe |
| fmt_axi | input | 1 | Key format: 1 split-channel, 0 single-channel |
| ahb_xid | input | 6 | Extended ID of a single-channel transaction |
| axi_awuser_hi | input | 8 | Write-channel user bits 15:8 |
| axi_awid | input | 6 | Write-channel ID |
| axi_aruser_hi | input | 8 | Read-channel user bits 15:8 |
| axi_arid | input | 6 | Read-channel ID |
| tag_valid | output | 1 | Tag outputs hold a fresh result |
| tag_did | output | DID_W (4) | Domain identifier |
| tag_ns | output | 1 | Nonsecure attribute |
| tag_priv | output | 1 | Privileged attribute |
| tag_miss | output | 1 | No descriptor matched this request |
| nomatch_sticky | output | 1 | At least one request has missed since reset |

## Verification
Each tag is due exactly one clock edge after the request strobe. The bench drives a request on a falling edge, removes it on the next falling edge, and reads the tag at that moment, which is between the capturing edge and the following one. A table write lands on the same single edge. The write-then-request ordering is therefore checked by raising a write and a request together, where the old result is expected, and then issuing a second request, where the new result is expected. The lock and reset rules are observed through the tags that later requests receive, because the table has no read path.

// File: rtl/dtag_pkg.sv
package dtag_pkg;
  localparam int KEY_W         = 28;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_NS_BIT   = 1;
  localparam int CTRL_PRIV_BIT = 2;
  localparam int CTRL_DID_LSB  = 4;
  localparam int CTRL_LOCK_BIT = 31;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_word_e;
endpackage

// File: rtl/dtag_key_fmt.sv
module dtag_key_fmt
  import dtag_pkg::*;
(
  input  logic             fmt_axi,
  input  logic [5:0]       ahb_xid,
  input  logic [7:0]       axi_awuser_hi,
  input  logic [5:0]       axi_awid,
  input  logic [7:0]       axi_aruser_hi,
  input  logic [5:0]       axi_arid,
  output logic [KEY_W-1:0] key
);
  logic [KEY_W-1:0] key_axi;
  logic [KEY_W-1:0] key_ahb;

  // split-channel layout: write fields above read fields
  assign key_axi = {axi_awuser_hi, axi_awid, axi_aruser_hi, axi_arid};
  assign key_ahb = {{(KEY_W-6){1'b0}}, ahb_xid};
  assign key     = fmt_axi ? key_axi : key_ahb;
endmodule

// File: rtl/dtag_desc_table.sv
module dtag_desc_table
  import dtag_pkg::*;
#(
  parameter int NUM_DESC = 16,
  parameter int DID_W    = 4,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_wr,
  input  logic [IDX_W-1:0]                 cfg_idx,
  input  logic [1:0]                       cfg_sel,
  input  logic [31:0]                      cfg_data,
  output logic [NUM_DESC-1:0]              en_q,
  output logic [NUM_DESC-1:0]              ns_q,
  output logic [NUM_DESC-1:0]              priv_q,
  output logic [NUM_DESC-1:0]              lock_q,
  output logic [NUM_DESC-1:0][DID_W-1:0]   did_q,
  output logic [NUM_DESC-1:0][KEY_W-1:0]   cmp_q,
  output logic [NUM_DESC-1:0][KEY_W-1:0]   mask_q
);
  cfg_word_e  word;
  logic       idx_ok;
  logic       wr_ok;

  assign word   = cfg_word_e'(cfg_sel);
  assign idx_ok = (32'(cfg_idx) < NUM_DESC);
  assign wr_ok  = cfg_wr && idx_ok && !lock_q[cfg_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        en_q[i]   <= 1'b0;
        ns_q[i]   <= 1'b0;
        priv_q[i] <= 1'b0;
        lock_q[i] <= 1'b0;
        did_q[i]  <= '0;
        cmp_q[i]  <= '0;
        mask_q[i] <= '0;
      end
    end else if (wr_ok) begin
      unique case (word)
        SEL_CTRL: begin
          en_q[cfg_idx]   <= cfg_data[CTRL_EN_BIT];
          ns_q[cfg_idx]   <= cfg_data[CTRL_NS_BIT];
          priv_q[cfg_idx] <= cfg_data[CTRL_PRIV_BIT];
          did_q[cfg_idx]  <= cfg_data[CTRL_DID_LSB +: DID_W];
          lock_q[cfg_idx] <= cfg_data[CTRL_LOCK_BIT];
        end
        SEL_CMP:  cmp_q[cfg_idx]  <= cfg_data[KEY_W-1:0];
        SEL_MASK: mask_q[cfg_idx] <= cfg_data[KEY_W-1:0];
        default: ;
      endcase
    end
  end

  // a locked descriptor keeps every field until reset
  for (genvar g = 0; g < NUM_DESC; g++) begin : g_lock_chk
    assert_lock_hold_R10: assert property (@(posedge clk) disable iff (rst)
      lock_q[g] |=> ($stable(cmp_q[g]) && $stable(mask_q[g]) && $stable(did_q[g])
                     && $stable(en_q[g]) && $stable(ns_q[g]) && $stable(priv_q[g])
                     && lock_q[g]));
  end
endmodule

// File: rtl/dtag_match_unit.sv
module dtag_match_unit
  import dtag_pkg::*;
#(
  parameter int NUM_DESC = 16,
  parameter int DID_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [KEY_W-1:0]               key,
  input  logic [NUM_DESC-1:0]            en,
  input  logic [NUM_DESC-1:0]            ns,
  input  logic [NUM_DESC-1:0]            priv,
  input  logic [NUM_DESC-1:0][DID_W-1:0] did,
  input  logic [NUM_DESC-1:0][KEY_W-1:0] cmp,
  input  logic [NUM_DESC-1:0][KEY_W-1:0] mask,
  output logic                           hit_any,
  output logic [DID_W-1:0]               sel_did,
  output logic                           sel_ns,
  output logic                           sel_priv
);
  logic [NUM_DESC-1:0] hit_vec;
  logic [NUM_DESC-1:0] win_vec;
  logic                found;
  logic [DID_W-1:0]    or_did;
  logic                or_ns;
  logic                or_priv;

  // one masked comparator per descriptor
  for (genvar g = 0; g < NUM_DESC; g++) begin : g_cmp
    assign hit_vec[g] = en[g] && (((key ^ cmp[g]) & ~mask[g]) == '0);
  end

  // lowest index wins
  always_comb begin
    win_vec = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (hit_vec[i] && !found) begin
        win_vec[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    or_did  = '0;
    or_ns   = 1'b0;
    or_priv = 1'b0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (win_vec[i]) begin
        or_did  = or_did | did[i];
        or_ns   = or_ns | ns[i];
        or_priv = or_priv | priv[i];
      end
    end
  end

  assign hit_any  = found;
  assign sel_did  = found ? or_did  : '0;
  assign sel_ns   = found ? or_ns   : 1'b1;
  assign sel_priv = found ? or_priv : 1'b0;

  assert_single_winner_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_vec));

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_en_chk
    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !en[g] |-> !win_vec[g]);
  end
endmodule

// File: rtl/domain_tagger.sv
module domain_tagger
  import dtag_pkg::*;
#(
  parameter int NUM_DESC = 16,
  parameter int DID_W    = 4,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_data,
  input  logic             req_valid,
  input  logic             fmt_axi,
  input  logic [5:0]       ahb_xid,
  input  logic [7:0]       axi_awuser_hi,
  input  logic [5:0]       axi_awid,
  input  logic [7:0]       axi_aruser_hi,
  input  logic [5:0]       axi_arid,
  output logic             tag_valid,
  output logic [DID_W-1:0] tag_did,
  output logic             tag_ns,
  output logic             tag_priv,
  output logic             tag_miss,
  output logic             nomatch_sticky
);
  logic [KEY_W-1:0]               key;
  logic [NUM_DESC-1:0]            en_q, ns_q, priv_q, lock_q;
  logic [NUM_DESC-1:0][DID_W-1:0] did_q;
  logic [NUM_DESC-1:0][KEY_W-1:0] cmp_q, mask_q;
  logic                           hit_any;
  logic [DID_W-1:0]               sel_did;
  logic                           sel_ns, sel_priv;

  dtag_key_fmt u_fmt (
    .fmt_axi(fmt_axi), .ahb_xid(ahb_xid),
    .axi_awuser_hi(axi_awuser_hi), .axi_awid(axi_awid),
    .axi_aruser_hi(axi_aruser_hi), .axi_arid(axi_arid),
    .key(key)
  );

  dtag_desc_table #(.NUM_DESC(NUM_DESC), .DID_W(DID_W)) u_table (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .en_q(en_q), .ns_q(ns_q), .priv_q(priv_q), .lock_q(lock_q),
    .did_q(did_q), .cmp_q(cmp_q), .mask_q(mask_q)
  );

  dtag_match_unit #(.NUM_DESC(NUM_DESC), .DID_W(DID_W)) u_match (
    .clk(clk), .rst(rst), .key(key),
    .en(en_q), .ns(ns_q), .priv(priv_q), .did(did_q),
    .cmp(cmp_q), .mask(mask_q),
    .hit_any(hit_any), .sel_did(sel_did), .sel_ns(sel_ns), .sel_priv(sel_priv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_valid      <= 1'b0;
      tag_did        <= '0;
      tag_ns         <= 1'b0;
      tag_priv       <= 1'b0;
      tag_miss       <= 1'b0;
      nomatch_sticky <= 1'b0;
    end else begin
      tag_valid <= req_valid;
      if (req_valid) begin
        tag_did  <= sel_did;
        tag_ns   <= sel_ns;
        tag_priv <= sel_priv;
        tag_miss <= !hit_any;
        if (!hit_any) nomatch_sticky <= 1'b1;
      end
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tag_valid == $past(req_valid)));

  assert_miss_default_R5: assert property (@(posedge clk) disable iff (rst)
    (tag_valid && tag_miss) |-> (tag_did == '0 && tag_ns && !tag_priv));

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
    nomatch_sticky |=> nomatch_sticky);

  assert_sticky_set_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit_any) |=> nomatch_sticky);
endmodule

// File: tb/domain_tagger_test.sv
`timescale 1ns/1ps
module domain_tagger_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        fmt_axi = 1'b1;
  logic [5:0]  ahb_xid = '0;
  logic [7:0]  awu = '0;
  logic [5:0]  awid = '0;
  logic [7:0]  aru = '0;
  logic [5:0]  arid = '0;
  logic        tag_valid, tag_ns, tag_priv, tag_miss, nomatch_sticky;
  logic [3:0]  tag_did;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  domain_tagger uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .req_valid(req_valid),
    .fmt_axi(fmt_axi), .ahb_xid(ahb_xid),
    .axi_awuser_hi(awu), .axi_awid(awid), .axi_aruser_hi(aru), .axi_arid(arid),
    .tag_valid(tag_valid), .tag_did(tag_did), .tag_ns(tag_ns),
    .tag_priv(tag_priv), .tag_miss(tag_miss), .nomatch_sticky(nomatch_sticky)
  );

  function automatic logic [31:0] ctrl(bit en, bit ns, bit pv, logic [3:0] d, bit lk);
    return {lk, 23'd0, d, 1'b0, pv, ns, en};
  endfunction

  function automatic logic [31:0] axkey(logic [7:0] a, logic [5:0] b, logic [7:0] c, logic [5:0] e);
    return {4'd0, a, b, c, e};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {valid, miss, ns, priv, did}
  task automatic expect_tag(string req, bit m, bit ns, bit pv, logic [3:0] d);
    check(req, {tag_valid, tag_miss, tag_ns, tag_priv, tag_did}, {1'b1, m, ns, pv, d});
  endtask

  task automatic wr(logic [3:0] idx, logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_data = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send_axi(logic [7:0] a, logic [5:0] b, logic [7:0] c, logic [5:0] e);
    @(negedge clk);
    req_valid = 1'b1; fmt_axi = 1'b1; awu = a; awid = b; aru = c; arid = e;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_ahb(logic [5:0] x);
    @(negedge clk);
    req_valid = 1'b1; fmt_axi = 1'b0; ahb_xid = x;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R11 valid after reset", {7'd0, tag_valid}, 8'd0);
    check("R11 sticky after reset", {7'd0, nomatch_sticky}, 8'd0);
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h11);
    expect_tag("R5 empty table default", 1'b1, 1'b1, 1'b0, 4'd0);
    check("R6 sticky set on miss", {7'd0, nomatch_sticky}, 8'd1);
    @(negedge clk);
    check("R1 valid drops after one cycle", {7'd0, tag_valid}, 8'd0);
  endtask

  task automatic t_ahb_format();
    wr(4'd2, 2'd1, 32'h0000_002A);
    wr(4'd2, 2'd2, 32'h0);
    wr(4'd2, 2'd0, ctrl(1, 1, 1, 4'd6, 0));
    send_ahb(6'h2A);
    expect_tag("R8 single-channel key hit", 1'b0, 1'b1, 1'b1, 4'd6);
    send_ahb(6'h2B);
    expect_tag("R8 single-channel key miss", 1'b1, 1'b1, 1'b0, 4'd0);
    wr(4'd2, 2'd0, ctrl(0, 0, 0, 4'd0, 0));
    send_ahb(6'h2A);
    expect_tag("R2 disabled entry ignored", 1'b1, 1'b1, 1'b0, 4'd0);
  endtask

  task automatic t_exact_and_mask();
    wr(4'd3, 2'd1, axkey(8'hC3, 6'h12, 8'h7E, 6'h11));
    wr(4'd3, 2'd2, 32'h0);
    wr(4'd3, 2'd0, ctrl(1, 0, 1, 4'd5, 0));
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h11);
    expect_tag("R3 exact hit", 1'b0, 1'b0, 1'b1, 4'd5);
    send_axi(8'hC3, 6'h13, 8'h7E, 6'h11);
    expect_tag("R3 one bit differs", 1'b1, 1'b1, 1'b0, 4'd0);
    wr(4'd3, 2'd2, 32'h0000_003F);
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h05);
    expect_tag("R3 masked bits ignored", 1'b0, 1'b0, 1'b1, 4'd5);
    check("R6 sticky holds across hits", {7'd0, nomatch_sticky}, 8'd1);
  endtask

  task automatic t_priority();
    wr(4'd1, 2'd2, 32'h0FFF_FFFF);
    wr(4'd1, 2'd0, ctrl(1, 1, 0, 4'd2, 0));
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h11);
    expect_tag("R4 lower index wins", 1'b0, 1'b1, 1'b0, 4'd2);
    wr(4'd1, 2'd0, ctrl(0, 1, 0, 4'd2, 0));
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h11);
    expect_tag("R2 disabled lower entry skipped", 1'b0, 1'b0, 1'b1, 4'd5);
  endtask

  task automatic t_axi_order();
    wr(4'd0, 2'd1, 32'h0A50_0000);
    wr(4'd0, 2'd2, 32'h000F_FFFF);
    wr(4'd0, 2'd0, ctrl(1, 0, 0, 4'd3, 0));
    send_axi(8'hA5, 6'h00, 8'h00, 6'h00);
    expect_tag("R7 write-user field in top bits", 1'b0, 1'b0, 1'b0, 4'd3);
    send_axi(8'h5A, 6'h00, 8'hA5, 6'h00);
    expect_tag("R7 read-user not in top bits", 1'b1, 1'b1, 1'b0, 4'd0);
    wr(4'd0, 2'd0, ctrl(0, 0, 0, 4'd0, 0));
  endtask

  task automatic t_last_index();
    wr(4'd15, 2'd2, 32'h0FFF_FFFF);
    wr(4'd15, 2'd0, ctrl(1, 1, 1, 4'd9, 0));
    send_axi(8'h00, 6'h3F, 8'h11, 6'h3F);
    expect_tag("R2 index 15 catches all", 1'b0, 1'b1, 1'b1, 4'd9);
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h11);
    expect_tag("R4 index 3 beats 15", 1'b0, 1'b0, 1'b1, 4'd5);
  endtask

  task automatic t_write_order();
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 4'd3; cfg_sel = 2'd0; cfg_data = ctrl(1, 0, 1, 4'd7, 0);
    req_valid = 1'b1; fmt_axi = 1'b1; awu = 8'hC3; awid = 6'h12; aru = 8'h7E; arid = 6'h11;
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    expect_tag("R9 same-cycle request sees old", 1'b0, 1'b0, 1'b1, 4'd5);
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h11);
    expect_tag("R9 later request sees new", 1'b0, 1'b0, 1'b1, 4'd7);
  endtask

  task automatic t_lock();
    wr(4'd3, 2'd0, ctrl(1, 0, 1, 4'd5, 1));
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h11);
    expect_tag("R10 locking write applied", 1'b0, 1'b0, 1'b1, 4'd5);
    wr(4'd3, 2'd1, 32'h0);
    wr(4'd3, 2'd0, ctrl(0, 1, 0, 4'd0, 0));
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h11);
    expect_tag("R10 locked entry unchanged", 1'b0, 1'b0, 1'b1, 4'd5);
  endtask

  task automatic t_reset_clears();
    do_reset();
    check("R6 sticky cleared by reset", {7'd0, nomatch_sticky}, 8'd0);
    check("R11 valid cleared", {7'd0, tag_valid}, 8'd0);
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h11);
    expect_tag("R11 table cleared", 1'b1, 1'b1, 1'b0, 4'd0);
    wr(4'd3, 2'd1, axkey(8'hC3, 6'h12, 8'h7E, 6'h11));
    wr(4'd3, 2'd0, ctrl(1, 1, 0, 4'd4, 0));
    send_axi(8'hC3, 6'h12, 8'h7E, 6'h11);
    expect_tag("R10 lock released by reset", 1'b0, 1'b1, 1'b0, 4'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_ahb_format();
    t_exact_and_mask();
    t_priority();
    t_axi_order();
    t_last_index();
    t_write_order();
    t_lock();
    t_reset_clears();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule